// File: doc/BRIEF.md
# Event Record Builder

After conversion, this block turns the stored results of one event into a fixed sequence of formatted words and writes them into an on-chip SRAM. A single start pulse begins the record. The block then writes one word for each channel in ascending channel order, one time-stamp word and one chip-identity word. Each word goes into the next SRAM location. When the chip-identity word has been written, the count of complete events goes up, and a readout engine uses that count.

A channel word packs the low 12 bits of the crossing number, the 12-bit converted value, the bit that tells which of the two gain ranges was converted, and the hit flag. The crossing number is captured when the start pulse is accepted. The channel results, gain bits, hit bits and chip identity are read directly from the inputs, so they must stay stable until the record ends.

Before a record begins, the block checks that the whole record fits in the remaining SRAM. If it does not fit, nothing is written, the overflow flag rises, and the block stays full until reset. A start pulse that arrives during the chip-identity write is accepted, so records can run back to back with no idle cycle between them.

The controller states are:
- IDLE: waits for start.
- CHAN: writes the channel words.
- STAMP: writes the time-stamp word.
- CHIPID: writes the identity word and may accept the next start.
- FULL: a terminal state entered when a record will not fit.

The transitions are:
- IDLE→CHAN on a start that fits.
- IDLE→FULL on a start that does not fit.
- CHAN→CHAN until the last channel.
- CHAN→STAMP after the last channel.
- STAMP→CHIPID.
- CHIPID→CHAN on a start that fits.
- CHIPID→FULL on a start that does not fit.
- CHIPID→IDLE with no start.
- FULL→FULL.

Top module: `event_builder`

## Requirements
- R1: While reset is asserted and right after it: write enable 0, address 0, event count 0, busy 0, overflow 0.
- R2: A start in IDLE that fits causes the channel words for channels 0 to 35 to be written in ascending order in the 36 cycles after the accepting edge, with write enable and busy high.
- R3: A channel word is {ts[11:0] in bits 25:14, converted value in bits 13:2, gain bit in bit 1, hit bit in bit 0}.
- R4: The cycle after channel 35 writes the time-stamp word: the captured crossing number bits 11:0 in bits 25:14, with bits 13:0 zero.
- R5: The cycle after the time-stamp word writes the chip-identity word: the 8-bit identity in bits 7:0, with bits 25:8 zero.
- R6: The write address starts at 0 after reset and increases by one for each written word, continuing across events.
- R7: The event count increases by one at the clock edge that ends the chip-identity write, and at no other time.
- R8: A start during CHAN or STAMP is ignored: the record continues unchanged, and with no later start the block returns to idle (write enable and busy low) after the identity word.
- R9: A start during the chip-identity write cycle is accepted: the next cycle writes channel 0 of the new event at the next address.
- R10: A start when fewer than 38 free words remain writes nothing, sets overflow, and leaves it set until reset; later starts also write nothing, and the event count stays unchanged.
- R11: The crossing number is sampled only at the accepting edge; later changes on its input do not alter that event's words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to build one event record |
| adc_i | input | 432 | Converted values, channel c in bits 12c+11:12c |
| gain_i | input | 36 | Gain range bit per channel |
| hit_i | input | 36 | Hit flag per channel |
| bcid_i | input | 24 | Crossing counter value |
| chip_id_i | input | 8 | Chip identity |
| busy_o | output | 1 | A record is being written |
| sram_we_o | output | 1 | SRAM write enable |
| sram_addr_o | output | 10 | SRAM write address |
| sram_wdata_o | output | 26 | SRAM write data |
| event_cnt_o | output | 5 | Number of complete events stored |
| overflow_o | output | 1 | A record was refused for lack of room |

## Verification
Two things can land in the same cycle: finishing one record, which writes the identity word and raises the count, and accepting the next start together with its room check. The bench provokes this by raising start during the identity-write cycle. It then checks that the next cycle carries channel 0 of the new event at the next address, that the new crossing number appears in it, and that the count has gone up by exactly one. A second case puts a spurious start in the middle of a record, while the crossing input holds a different value, and checks that the words and the final return to idle are unchanged.

// File: rtl/eb_pkg.sv
package eb_pkg;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_CHAN   = 3'd1,
        S_STAMP  = 3'd2,
        S_CHIPID = 3'd3,
        S_FULL   = 3'd4
    } eb_state_t;

endpackage

// File: rtl/eb_chan_sel.sv
// Selects one channel's converted value, gain and hit bits by index.
module eb_chan_sel #(
    parameter int NCH   = 36,
    parameter int ADC_W = 12,
    parameter int CHW   = 6
) (
    input  logic [NCH*ADC_W-1:0] adc_flat,
    input  logic [NCH-1:0]       gain_flat,
    input  logic [NCH-1:0]       hit_flat,
    input  logic [CHW-1:0]       sel,
    output logic [ADC_W-1:0]     adc_o,
    output logic                 gain_o,
    output logic                 hit_o
);

    logic [ADC_W-1:0] adc_arr [0:NCH-1];

    for (genvar i = 0; i < NCH; i++) begin : g_unpack
        assign adc_arr[i] = adc_flat[i*ADC_W +: ADC_W];
    end

    assign adc_o  = adc_arr[sel];
    assign gain_o = gain_flat[sel];
    assign hit_o  = hit_flat[sel];

endmodule

// File: rtl/eb_room.sv
// Says whether a full record starting at 'base' still fits below DEPTH.
module eb_room #(
    parameter int DEPTH = 1024,
    parameter int EVW   = 38,
    parameter int PW    = 11
) (
    input  logic [PW-1:0] base,
    output logic          fits
);

    localparam logic [PW:0] LIMIT = (PW+1)'(DEPTH - EVW);

    assign fits = ({1'b0, base} <= LIMIT);

endmodule

// File: rtl/eb_evcount.sv
// Counts complete event records.
module eb_evcount #(
    parameter int ECW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           inc,
    output logic [ECW-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/event_builder.sv
module event_builder
    import eb_pkg::*;
#(
    parameter int NCH    = 36,
    parameter int ADC_W  = 12,
    parameter int TS_W   = 12,
    parameter int BCID_W = 24,
    parameter int ID_W   = 8,
    parameter int DEPTH  = 1024,
    localparam int EVW   = NCH + 2,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = $clog2(DEPTH + 1),
    localparam int CHW   = $clog2(NCH),
    localparam int WW    = TS_W + ADC_W + 2,
    localparam int ECW   = $clog2(DEPTH / EVW + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [NCH*ADC_W-1:0] adc_i,
    input  logic [NCH-1:0]       gain_i,
    input  logic [NCH-1:0]       hit_i,
    input  logic [BCID_W-1:0]    bcid_i,
    input  logic [ID_W-1:0]      chip_id_i,
    output logic                 busy_o,
    output logic                 sram_we_o,
    output logic [AW-1:0]        sram_addr_o,
    output logic [WW-1:0]        sram_wdata_o,
    output logic [ECW-1:0]       event_cnt_o,
    output logic                 overflow_o
);

    eb_state_t        state, state_nx;
    logic [CHW-1:0]   ch_idx;
    logic [PW-1:0]    wptr;
    logic [TS_W-1:0]  ts_q;
    logic [PW-1:0]    room_base;
    logic             room_ok;
    logic             take_start;
    logic [ADC_W-1:0] cur_adc;
    logic             cur_gain;
    logic             cur_hit;

    // Room is judged from the address the next record would start at.
    assign room_base  = (state == S_CHIPID) ? wptr + 1'b1 : wptr;
    assign take_start = start_i && (state == S_IDLE || state == S_CHIPID);

    eb_room #(.DEPTH(DEPTH), .EVW(EVW), .PW(PW)) u_room (
        .base (room_base),
        .fits (room_ok)
    );

    eb_chan_sel #(.NCH(NCH), .ADC_W(ADC_W), .CHW(CHW)) u_sel (
        .adc_flat  (adc_i),
        .gain_flat (gain_i),
        .hit_flat  (hit_i),
        .sel       (ch_idx),
        .adc_o     (cur_adc),
        .gain_o    (cur_gain),
        .hit_o     (cur_hit)
    );

    eb_evcount #(.ECW(ECW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (state == S_CHIPID),
        .count (event_cnt_o)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (start_i) state_nx = room_ok ? S_CHAN : S_FULL;
            end
            S_CHAN: begin
                if (ch_idx == CHW'(NCH - 1)) state_nx = S_STAMP;
            end
            S_STAMP: begin
                state_nx = S_CHIPID;
            end
            S_CHIPID: begin
                if (start_i) state_nx = room_ok ? S_CHAN : S_FULL;
                else         state_nx = S_IDLE;
            end
            S_FULL: begin
                state_nx = S_FULL;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // State register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            ch_idx <= '0;
            wptr   <= '0;
            ts_q   <= '0;
        end else begin
            state <= state_nx;
            if (take_start && room_ok) begin
                ts_q <= bcid_i[TS_W-1:0];
            end
            if (state == S_CHAN) begin
                ch_idx <= ch_idx + 1'b1;
            end else begin
                ch_idx <= '0;
            end
            if (sram_we_o) begin
                wptr <= wptr + 1'b1;
            end
        end
    end

    // Output logic
    always_comb begin
        busy_o       = 1'b0;
        sram_we_o    = 1'b0;
        sram_wdata_o = '0;
        overflow_o   = 1'b0;
        unique case (state)
            S_IDLE: begin
            end
            S_CHAN: begin
                busy_o       = 1'b1;
                sram_we_o    = 1'b1;
                sram_wdata_o = {ts_q, cur_adc, cur_gain, cur_hit};
            end
            S_STAMP: begin
                busy_o       = 1'b1;
                sram_we_o    = 1'b1;
                sram_wdata_o = {ts_q, {(WW-TS_W){1'b0}}};
            end
            S_CHIPID: begin
                busy_o       = 1'b1;
                sram_we_o    = 1'b1;
                sram_wdata_o = {{(WW-ID_W){1'b0}}, chip_id_i};
            end
            S_FULL: begin
                overflow_o = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign sram_addr_o = wptr[AW-1:0];

endmodule

// File: rtl/eb_checker.sv
module eb_checker #(
    parameter int AW  = 10,
    parameter int ECW = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy_o,
    input logic           sram_we_o,
    input logic [AW-1:0]  sram_addr_o,
    input logic [ECW-1:0] event_cnt_o,
    input logic           overflow_o
);

    // R6: consecutive writes use consecutive addresses
    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_we_o && $past(sram_we_o)) |-> (sram_addr_o == $past(sram_addr_o) + 1'b1));

    // R7: the count only steps by one, and only after a write cycle
    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (event_cnt_o != $past(event_cnt_o)) |->
            ((event_cnt_o == $past(event_cnt_o) + 1'b1) && $past(sram_we_o)));

    // R10: overflow stays set until reset
    p_overflow_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);

    // R10: nothing is written once full
    p_full_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> (!sram_we_o && !busy_o));

    // R2: writes happen only inside a record
    p_write_in_record_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we_o |-> busy_o);

endmodule

bind event_builder eb_checker #(.AW(AW), .ECW(ECW)) u_eb_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .sram_we_o   (sram_we_o),
    .sram_addr_o (sram_addr_o),
    .event_cnt_o (event_cnt_o),
    .overflow_o  (overflow_o)
);

// File: tb/tb_event_builder.sv
module tb_event_builder;

    localparam int NCH   = 36;
    localparam int ADC_W = 12;
    localparam int DEPTH = 1024;
    localparam int EVW   = NCH + 2;
    localparam int NV    = 4;

    localparam logic [23:0] T_BC    [NV] = '{24'h00A5C3, 24'hFFFFFF, 24'h123000, 24'h000FFF};
    localparam logic [11:0] T_SD    [NV] = '{12'h0F3, 12'hFFF, 12'h000, 12'h5A1};
    localparam bit          T_CHAIN [NV] = '{1'b1, 1'b1, 1'b0, 1'b0};
    localparam bit          T_POKE  [NV] = '{1'b0, 1'b0, 1'b0, 1'b1};

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start_i = 1'b0;
    logic [NCH*ADC_W-1:0] adc_i = '0;
    logic [NCH-1:0]       gain_i = '0;
    logic [NCH-1:0]       hit_i = '0;
    logic [23:0]          bcid_i = '0;
    logic [7:0]           chip_id_i = 8'hC7;
    logic                 busy_o;
    logic                 sram_we_o;
    logic [9:0]           sram_addr_o;
    logic [25:0]          sram_wdata_o;
    logic [4:0]           event_cnt_o;
    logic                 overflow_o;

    int  n_run = 0;
    int  n_fail = 0;
    int  exp_addr = 0;
    int  exp_cnt = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    event_builder dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .adc_i        (adc_i),
        .gain_i       (gain_i),
        .hit_i        (hit_i),
        .bcid_i       (bcid_i),
        .chip_id_i    (chip_id_i),
        .busy_o       (busy_o),
        .sram_we_o    (sram_we_o),
        .sram_addr_o  (sram_addr_o),
        .sram_wdata_o (sram_wdata_o),
        .event_cnt_o  (event_cnt_o),
        .overflow_o   (overflow_o)
    );

    function automatic logic [11:0] f_adc(input logic [11:0] sd, input int c);
        if (sd == 12'h000) return 12'h000;
        if (sd == 12'hFFF) return 12'hFFF;
        return 12'(int'(sd) * 7 + c * 293);
    endfunction

    function automatic logic f_gain(input logic [11:0] sd, input int c);
        if (sd == 12'h000) return 1'b0;
        if (sd == 12'hFFF) return 1'b1;
        return ((c + int'(sd)) % 3) == 0;
    endfunction

    function automatic logic f_hit(input logic [11:0] sd, input int c);
        if (sd == 12'h000) return 1'b0;
        if (sd == 12'hFFF) return 1'b1;
        return ((c ^ int'(sd)) & 1) == 1;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive_ch(input logic [11:0] sd);
        for (int c = 0; c < NCH; c++) begin
            adc_i[c*ADC_W +: ADC_W] = f_adc(sd, c);
            gain_i[c] = f_gain(sd, c);
            hit_i[c]  = f_hit(sd, c);
        end
    endtask

    task automatic do_event(input logic [23:0] bc, input logic [11:0] sd, input bit pre,
                            input bit chain, input logic [23:0] nbc, input logic [11:0] nsd,
                            input bit poke);
        logic [25:0] w_exp;
        if (!pre) begin
            @(negedge clk);
            bcid_i = bc;
            drive_ch(sd);
            start_i = 1'b1;
            @(negedge clk);
        end
        start_i = 1'b0;
        for (int w = 0; w < EVW; w++) begin
            if (w < NCH)       w_exp = {bc[11:0], f_adc(sd, w), f_gain(sd, w), f_hit(sd, w)};
            else if (w == NCH) w_exp = {bc[11:0], 14'h0};
            else               w_exp = {18'h0, chip_id_i};
            if (w < NCH)       chk(sram_we_o && busy_o && sram_wdata_o == w_exp, "R2/R3/R11 channel word", 64'(sram_wdata_o), 64'(w_exp));
            else if (w == NCH) chk(sram_we_o && sram_wdata_o == w_exp, "R4/R11 stamp word", 64'(sram_wdata_o), 64'(w_exp));
            else               chk(sram_we_o && sram_wdata_o == w_exp, "R5 chip id word", 64'(sram_wdata_o), 64'(w_exp));
            chk(sram_addr_o == 10'(exp_addr), (pre && w == 0) ? "R9 chained address" : "R6 address", 64'(sram_addr_o), 64'(exp_addr));
            if (w == 1) bcid_i = ~bc;
            if (poke && w == 10) start_i = 1'b1;
            if (poke && w == 11) start_i = 1'b0;
            if (poke && w == NCH) start_i = 1'b1;
            if (poke && w == NCH + 1) start_i = 1'b0;
            if (w == EVW - 1 && chain) begin
                bcid_i = nbc;
                drive_ch(nsd);
                start_i = 1'b1;
            end
            exp_addr++;
            @(negedge clk);
        end
        exp_cnt++;
        chk(event_cnt_o == 5'(exp_cnt), "R7 event count", 64'(event_cnt_o), 64'(exp_cnt));
        if (!chain) begin
            chk(!sram_we_o && !busy_o, "R8 return to idle", 64'({sram_we_o, busy_o}), 64'(0));
        end
    endtask

    task automatic check_reset_state(input string tag);
        chk(!sram_we_o && !busy_o && !overflow_o && sram_addr_o == 10'd0 && event_cnt_o == 5'd0,
            tag, 64'({sram_we_o, busy_o, overflow_o, sram_addr_o, event_cnt_o}), 64'(0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state("R1 reset asserted");
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("R1 after reset");

        // Table-driven events: chaining (R9), mid-record start (R8), bcid change (R11)
        for (int i = 0; i < NV; i++) begin
            do_event(T_BC[i], T_SD[i], (i > 0) ? T_CHAIN[i-1] : 1'b0, T_CHAIN[i],
                     (i < NV - 1) ? T_BC[i+1] : 24'h0, (i < NV - 1) ? T_SD[i+1] : 12'h0, T_POKE[i]);
        end

        // Fill the memory with whole records
        for (int k = 0; exp_addr + EVW <= DEPTH; k++) begin
            chk(!overflow_o, "R10 no early overflow", 64'(overflow_o), 64'(0));
            do_event(24'(k * 4099 + 17), 12'(k * 91 + 3), 1'b0, 1'b0, 24'h0, 12'h0, 1'b0);
        end

        // R10: refused record
        for (int t = 0; t < 2; t++) begin
            @(negedge clk);
            bcid_i = 24'h0ABCDE;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            for (int c = 0; c < EVW + 2; c++) begin
                chk(!sram_we_o && !busy_o, "R10 no write when full", 64'(sram_we_o), 64'(0));
                @(negedge clk);
            end
            chk(overflow_o, "R10 overflow set", 64'(overflow_o), 64'(1));
            chk(event_cnt_o == 5'(exp_cnt), "R10 count unchanged", 64'(event_cnt_o), 64'(exp_cnt));
        end

        // Reset clears everything, then a record starts at address 0
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_reset_state("R1 reset from full");
        rst_n = 1'b1;
        exp_addr = 0;
        exp_cnt = 0;
        do_event(24'h000001, 12'h3C3, 1'b0, 1'b0, 24'h0, 12'h0, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule